// File: doc/BRIEF.md
# Saturating Edge Tally with Capture Register

This block counts qualified input edges in an 8-bit register. Each cycle in which the edge strobe is high advances the count by one. When the count is already at its top value, a mode bit picks the policy. In wrap mode the count rolls over to zero. In saturate mode it holds at the top value, which then reads as "255 or more".

A capture register keeps a snapshot of the count. Capture happens only when both the buffer-enable bit and the latch-mode bit are set. In that state, a capture strobe copies the current count into the capture register and clears the live counter in the same clock. The capture strobe stands for any of three sources: a down-counter reaching zero, a zero written to that down-counter, or a software command. Whenever buffering is off, the capture register is forced to zero and stays there. A preload port lets the live counter be written directly.

When several inputs arrive in the same cycle, they are resolved in a fixed priority order:

- A capture beats a preload, and a preload beats an edge.
- An edge that coincides with a capture is not lost. The snapshot takes the value before the increment, and the counter restarts at one.

Top module: `edge_tally`

## Requirements
- R1: While `rst` is high at a clock edge, `count` and `held` both become 0x00 after that edge.
- R2: An edge strobe with no capture or preload raises `count` by exactly one at the next clock, when `count` is below 0xFF.
- R3: With `sat_mode` = 0, an edge strobe while `count` = 0xFF makes `count` 0x00.
- R4: With `sat_mode` = 1, an edge strobe while `count` = 0xFF leaves `count` at 0xFF.
- R5: A capture strobe with `buf_en` = 1 and `latch_mode` = 1, and no edge, sets `held` to the prior `count` and `count` to 0x00.
- R6: An edge strobe in the same cycle as an accepted capture puts the pre-increment `count` into `held` and sets `count` to 0x01.
- R7: A capture strobe with `buf_en` = 0 or `latch_mode` = 0 changes neither `count` nor `held`; a coincident edge still counts normally.
- R8: While `buf_en` = 0, `held` reads 0x00 from the next clock on.
- R9: `load_en` = 1 writes `load_val` into `count` and takes priority over an edge strobe, but an accepted capture takes priority over the preload.
- R10: With no edge, capture or preload, `count` and `held` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_stb | input | 1 | One-cycle strobe per qualified input edge |
| sat_mode | input | 1 | 1 = stop at top value, 0 = roll over |
| buf_en | input | 1 | Enables the capture register |
| latch_mode | input | 1 | 1 = capture strobes are acted on |
| cap_stb | input | 1 | Capture strobe (down-counter zero or software command) |
| load_en | input | 1 | Preload write enable for the live counter |
| load_val | input | CNT_W | Preload value |
| count | output | CNT_W | Live counter value |
| held | output | CNT_W | Capture register value |

## Verification
The bench builds the block with its default `CNT_W` of 8, so the top value is 0xFF.

The preload port brings the top value within one or two cycles, which lets the vector table exercise the wrap, saturate and coincident-capture-at-top cases directly. Long directed runs cover other ground:

- 256 consecutive edges in wrap mode cover the full roll-over cycle.
- More than 255 edges in saturate mode confirm that the count sticks at the top value.

// File: rtl/edge_tally_pkg.sv
package edge_tally_pkg;

    localparam int TALLY_W_DEF = 8;

    // What the live counter does this cycle, in priority order
    typedef enum logic [1:0] {
        ACT_KEEP    = 2'd0,
        ACT_STEP    = 2'd1,
        ACT_LOAD    = 2'd2,
        ACT_CAPTURE = 2'd3
    } tally_act_e;

    typedef struct packed {
        tally_act_e act;        // counter action
        logic       step_also;  // edge coincides with capture
        logic       snap;       // copy count into capture register
        logic       wipe_held;  // capture register disabled
    } tally_ctl_s;

    function automatic tally_ctl_s decode_ctl(
        input logic edge_in,
        input logic cap_in,
        input logic buf_on,
        input logic latch_on,
        input logic load_in
    );
        tally_ctl_s c;
        logic       take;
        take        = cap_in & buf_on & latch_on;
        c.snap      = take;
        c.wipe_held = ~buf_on;
        c.step_also = take & edge_in;
        if (take)         c.act = ACT_CAPTURE;
        else if (load_in) c.act = ACT_LOAD;
        else if (edge_in) c.act = ACT_STEP;
        else              c.act = ACT_KEEP;
        return c;
    endfunction

endpackage

// File: rtl/edge_tally_decode.sv
module edge_tally_decode
    import edge_tally_pkg::*;
(
    input  logic       edge_stb,
    input  logic       cap_stb,
    input  logic       buf_en,
    input  logic       latch_mode,
    input  logic       load_en,
    output tally_ctl_s ctl
);

    always_comb begin
        ctl = decode_ctl(edge_stb, cap_stb, buf_en, latch_mode, load_en);
    end

endmodule

// File: rtl/edge_tally_count.sv
module edge_tally_count
    import edge_tally_pkg::*;
#(
    parameter int CNT_W = TALLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  tally_ctl_s       ctl,
    input  logic             sat_mode,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] next_cnt;

    // Increment with top-value policy
    always_comb begin
        if (count == TOP) stepped = sat_mode ? TOP : ZERO;
        else              stepped = count + ONE;
    end

    always_comb begin
        unique case (ctl.act)
            ACT_CAPTURE: next_cnt = ctl.step_also ? ONE : ZERO;
            ACT_LOAD:    next_cnt = load_val;
            ACT_STEP:    next_cnt = stepped;
            default:     next_cnt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count <= ZERO;
        else     count <= next_cnt;
    end

endmodule

// File: rtl/edge_tally_hold.sv
module edge_tally_hold
    import edge_tally_pkg::*;
#(
    parameter int CNT_W = TALLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  tally_ctl_s       ctl,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst || ctl.wipe_held) held <= '0;
        else if (ctl.snap)        held <= count;
    end

endmodule

// File: rtl/edge_tally.sv
module edge_tally
    import edge_tally_pkg::*;
#(
    parameter int CNT_W = TALLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_stb,
    input  logic             sat_mode,
    input  logic             buf_en,
    input  logic             latch_mode,
    input  logic             cap_stb,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] held
);

    tally_ctl_s ctl;

    edge_tally_decode u_decode (
        .edge_stb   (edge_stb),
        .cap_stb    (cap_stb),
        .buf_en     (buf_en),
        .latch_mode (latch_mode),
        .load_en    (load_en),
        .ctl        (ctl)
    );

    edge_tally_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .sat_mode (sat_mode),
        .load_val (load_val),
        .count    (count)
    );

    edge_tally_hold #(.CNT_W(CNT_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .count (count),
        .held  (held)
    );

endmodule

// File: rtl/edge_tally_chk.sv
module edge_tally_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             edge_stb,
    input logic             sat_mode,
    input logic             buf_en,
    input logic             latch_mode,
    input logic             cap_stb,
    input logic             load_en,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] held
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic take;
    assign take = cap_stb & buf_en & latch_mode;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && held == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && !take && !load_en && count != TOP) |=> count == CNT_W'($past(count) + ONE));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && !take && !load_en && !sat_mode && count == TOP) |=> count == '0);

    assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && !take && !load_en && sat_mode && count == TOP) |=> count == TOP);

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (take && !edge_stb) |=> (count == '0 && held == $past(count)));

    assert_capture_edge_R6: assert property (@(posedge clk) disable iff (rst)
        (take && edge_stb) |=> (count == ONE && held == $past(count)));

    assert_capture_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && buf_en && !latch_mode && !edge_stb && !load_en) |=> ($stable(count) && $stable(held)));

    assert_held_off_R8: assert property (@(posedge clk) disable iff (rst)
        !buf_en |=> held == '0);

    assert_preload_R9: assert property (@(posedge clk) disable iff (rst)
        (load_en && !take) |=> count == $past(load_val));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!edge_stb && !cap_stb && !load_en && buf_en) |=> ($stable(count) && $stable(held)));

endmodule

bind edge_tally edge_tally_chk #(.CNT_W(CNT_W)) u_edge_tally_chk (
    .clk        (clk),
    .rst        (rst),
    .edge_stb   (edge_stb),
    .sat_mode   (sat_mode),
    .buf_en     (buf_en),
    .latch_mode (latch_mode),
    .cap_stb    (cap_stb),
    .load_en    (load_en),
    .load_val   (load_val),
    .count      (count),
    .held       (held)
);

// File: tb/test_edge_tally.sv
module test_edge_tally;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         edge_stb, sat_mode, buf_en, latch_mode, cap_stb, load_en;
    logic [W-1:0] load_val;
    logic [W-1:0] count, held;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;   // 100 MHz

    edge_tally #(.CNT_W(W)) i_edge_tally (
        .clk        (clk),
        .rst        (rst),
        .edge_stb   (edge_stb),
        .sat_mode   (sat_mode),
        .buf_en     (buf_en),
        .latch_mode (latch_mode),
        .cap_stb    (cap_stb),
        .load_en    (load_en),
        .load_val   (load_val),
        .count      (count),
        .held       (held)
    );

    typedef struct packed {
        logic       ed;
        logic       cp;
        logic       sat;
        logic       bf;
        logic       lm;
        logic       ld;
        logic [7:0] val;
        logic [7:0] exp_cnt;
        logic [7:0] exp_held;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h01,8'h00,8'd2},   // R2 first edge
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h02,8'h00,8'd2},   // R2 second edge
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h00,8'h02,8'h00,8'd7},   // R7 buffering off
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,8'h02,8'h00,8'd7},   // R7 latch mode off
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,8'h02,8'd5},   // R5 capture and clear
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h01,8'h02,8'd2},   // R2 count after capture
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,8'h00,8'h01,8'h01,8'd6},   // R6 edge with capture
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,8'hFE,8'hFE,8'h01,8'd9},   // R9 preload
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'hFF,8'h01,8'd2},   // R2 reach top
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,8'h01,8'd3},   // R3 wrap
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,8'hFF,8'hFF,8'h01,8'd9},   // R9 preload beats edge
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,8'hFF,8'h01,8'd4},   // R4 saturate
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,8'hFF,8'h01,8'd10},  // R10 idle
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,8'h01,8'hFF,8'd6},   // R6 capture at top
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h01,8'h00,8'd8},   // R8 held cleared
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h00,8'h02,8'h00,8'd7},   // R7 edge still counts
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'hAA,8'h00,8'h02,8'd9}    // R9 capture beats preload
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic ed, input logic cp, input logic sat,
                         input logic bf, input logic lm, input logic ld, input logic [W-1:0] v);
        edge_stb = ed; cap_stb = cp; sat_mode = sat;
        buf_en = bf; latch_mode = lm; load_en = ld; load_val = v;
        @(negedge clk);
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        edge_stb = 0; cap_stb = 0; sat_mode = 0; buf_en = 0;
        latch_mode = 0; load_en = 0; load_val = '0;
        repeat (3) @(negedge clk);
        check("R1 count after reset", count, 8'h00);
        check("R1 held after reset", held, 8'h00);
        rst = 1'b0;

        // Vector walk
        foreach (VECS[i]) begin
            drive(VECS[i].ed, VECS[i].cp, VECS[i].sat, VECS[i].bf, VECS[i].lm, VECS[i].ld, VECS[i].val);
            check($sformatf("R%0d vec %0d count", VECS[i].req, i), count, VECS[i].exp_cnt);
            check($sformatf("R%0d vec %0d held", VECS[i].req, i), held, VECS[i].exp_held);
        end

        // R1: reset from nonzero state
        drive(0, 0, 0, 1, 1, 1, 8'h55);
        drive(0, 1, 0, 1, 1, 0, 8'h00);   // held = 55
        drive(0, 0, 0, 1, 1, 1, 8'h33);
        rst = 1'b1;
        drive(1, 0, 0, 1, 1, 0, 8'h00);
        check("R1 count cleared by reset", count, 8'h00);
        check("R1 held cleared by reset", held, 8'h00);
        rst = 1'b0;

        // R4: more than 255 edges in saturate mode
        for (int k = 0; k < 300; k++) drive(1, 0, 1, 1, 1, 0, 8'h00);
        check("R4 saturated after 300 edges", count, 8'hFF);
        drive(0, 1, 1, 1, 1, 0, 8'h00);
        check("R5 capture of saturated count", held, 8'hFF);
        check("R5 count cleared on capture", count, 8'h00);

        // R2/R3: full wrap cycle
        for (int k = 0; k < 255; k++) drive(1, 0, 0, 1, 1, 0, 8'h00);
        check("R2 255 edges reach top", count, 8'hFF);
        drive(1, 0, 0, 1, 1, 0, 8'h00);
        check("R3 256th edge wraps", count, 8'h00);

        // R10: several idle cycles hold state
        drive(0, 0, 0, 1, 1, 1, 8'h7C);
        repeat (4) drive(0, 0, 0, 1, 1, 0, 8'h00);
        check("R10 count held across idle", count, 8'h7C);
        check("R10 held unchanged across idle", held, 8'hFF);

        // R8: buffering off keeps held at zero even with captures
        drive(0, 1, 0, 0, 1, 0, 8'h00);
        drive(0, 1, 0, 0, 1, 0, 8'h00);
        check("R8 held zero with buffering off", held, 8'h00);
        check("R7 count kept with buffering off", count, 8'h7C);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule